// File: doc/BRIEF.md
# Parallel ATA PIO Host Timing Engine

This block sits on the host side of a parallel ATA bus and runs one 16-bit programmed-I/O cycle per request. Each cycle targets a register or the data port. A requester presents a direction, an active-high chip-select pair, a 3-bit register address and, for writes, a data word. The engine then drives the bus pins through the address setup, the strobe, and the hold and recovery phases. It ends the cycle with a one-cycle `done` pulse, and for reads it returns the captured word.

All bus timing is counted in system clock cycles. The counts are derived at elaboration from nanosecond minimums for transfer modes 0 to 4, rounded up using the `CLK_NS` parameter. The mode is chosen per request. The IORDY input can stretch the strobe. A wait limit stops a device that never becomes ready from hanging the engine, and the cycle then ends with an error flag set.

Top module: `pio_host_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeoutErr` and `busDataOe` are 0. `busCsN` is 2'b11, and `busRdN` and `busWrN` are 1.
- R2: A request is taken when `reqValid` is high while `busy` is low. From the next cycle, `busy` stays high until the cycle in which `done` pulses high for exactly one clock. `busy` is low in that cycle.
- R3: After acceptance, the address and the chip selects are driven for ceil(t1/CLK_NS) cycles before the strobe falls. `busCsN[i]` is the inverse of `reqCs[i]`. The t1 values in ns are 70, 50, 30, 30 and 25 for modes 0 to 4.
- R4: While IORDY is high, the strobe stays low for ceil(t2/CLK_NS) cycles. The t2 values in ns are 165, 125, 100, 80 and 70 for modes 0 to 4.
- R5: After the strobe rises, the selects stay driven for a recovery period of max(ceil(t2i), ceil(t4), ceil(t9), ceil(t0)-ceil(t1)-ceil(t2)) cycles, where each ceiling is of the value divided by CLK_NS. `done` follows in the next cycle. Each count is at least 1. The values in ns for modes 0 to 4 are:
  - t0: 600, 383, 240, 180 and 120.
  - t2i: 0, 0, 0, 70 and 25.
  - t4: 30, 20, 15, 10 and 10.
  - t9: 20, 15, 10, 10 and 10.
- R6: A read (`reqWrite`=0) pulses `busRdN` only and never drives the data bus. The `busDataIn` value present at the clock edge where the strobe rises appears on `rdData` with `done`.
- R7: A write (`reqWrite`=1) pulses `busWrN` only. `busDataOut` carries the write word, and `busDataOe` is high from acceptance through the end of recovery.
- R8: The engine samples IORDY once the strobe has been low for ceil(35/CLK_NS) cycles. From then on, the strobe stays low while `ioRdy` is low. It rises on the first clock edge that sees `ioRdy` high after the R4 minimum is met.
- R9: If `ioRdy` is still low once the strobe has been low for ceil(35/CLK_NS)+ceil(MAX_WAIT_NS/CLK_NS) cycles, the strobe is released and the cycle completes normally. `timeoutErr` is then high with `done` and stays high until the next request is accepted, which clears it.
- R10: `reqValid` pulses and request field changes while `busy` is high have no effect. The bus keeps the accepted address, select and direction, and no further cycle follows.
- R11: The mode is sampled at acceptance. The `modeSel` values 5 to 7 give mode 4 timing.
- R12: `busAddr` and `busCsN` do not change while a strobe is low or in the cycle after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqCs | input | 2 | Active-high chip-select pair |
| reqAddr | input | 3 | Register address |
| reqWdata | input | 16 | Write data |
| modeSel | input | 3 | PIO transfer mode, 0 to 4 (higher values act as 4) |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Last cycle ended by the IORDY wait limit |
| rdData | output | 16 | Captured read data |
| busAddr | output | 3 | Bus address lines |
| busCsN | output | 2 | Active-low chip selects |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busDataOut | output | 16 | Bus data, host to device |
| busDataOe | output | 1 | Data bus output enable |
| busDataIn | input | 16 | Bus data, device to host |
| ioRdy | input | 1 | Device flow-control ready |

## Verification
Reads and writes run in modes 0, 1 and 4. Their measured setup, strobe and recovery lengths separate the per-mode tables, and they show the t0 stretch of the recovery in the slow modes from the t2i floor in the fast modes. A read with IORDY held low past its sample point, then released at a chosen count, shows the stretch is driven by the pin and not by a fixed delay. IORDY held low for good shows the wait limit, and the cycle after it shows the flag is cleared. A mid-cycle burst of conflicting requests and a mode code of 7 cover the ignore and clamp rules. The read data is changed right after the strobe rises, which shows which edge captures it.

// File: rtl/pio_host_pkg.sv
`timescale 1ns/1ps
package pio_host_pkg;

  localparam int NUM_MODES = 5;
  localparam int T_A_NS    = 35;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_RECOVER} pioState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;      // latch request fields
    logic driveBus;  // selects/address (and write data) on the bus
    logic strobeOn;  // strobe asserted
    logic capture;   // sample read data on this edge
  } pioCtl_t;

  function automatic int toCyc(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int cycleNs(int m);
    int r;
    case (m)
      0: r = 600;
      1: r = 383;
      2: r = 240;
      3: r = 180;
      default: r = 120;
    endcase
    return r;
  endfunction

  function automatic int setupNs(int m);
    int r;
    case (m)
      0: r = 70;
      1: r = 50;
      2: r = 30;
      3: r = 30;
      default: r = 25;
    endcase
    return r;
  endfunction

  function automatic int pulseNs(int m);
    int r;
    case (m)
      0: r = 165;
      1: r = 125;
      2: r = 100;
      3: r = 80;
      default: r = 70;
    endcase
    return r;
  endfunction

  function automatic int negNs(int m);
    int r;
    case (m)
      3: r = 70;
      4: r = 25;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic int wrHoldNs(int m);
    int r;
    case (m)
      0: r = 30;
      1: r = 20;
      2: r = 15;
      default: r = 10;
    endcase
    return r;
  endfunction

  function automatic int addrHoldNs(int m);
    int r;
    case (m)
      0: r = 20;
      1: r = 15;
      default: r = 10;
    endcase
    return r;
  endfunction

  // recovery cycles: largest of the negation/hold floors and the t0 remainder
  function automatic int recCyc(int m, int clkNs);
    int r;
    int rest;
    r = toCyc(negNs(m), clkNs);
    if (toCyc(wrHoldNs(m), clkNs) > r) r = toCyc(wrHoldNs(m), clkNs);
    if (toCyc(addrHoldNs(m), clkNs) > r) r = toCyc(addrHoldNs(m), clkNs);
    rest = toCyc(cycleNs(m), clkNs) - toCyc(setupNs(m), clkNs) - toCyc(pulseNs(m), clkNs);
    if (rest > r) r = rest;
    return r;
  endfunction

endpackage

// File: rtl/pio_host_ctrl.sv
`timescale 1ns/1ps
module pio_host_ctrl
  import pio_host_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int MAX_WAIT_NS = 1250
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic [2:0] modeSel,
  input  logic    ioRdy,
  output pioCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    timeoutErr
);

  localparam int TA_CYC   = toCyc(T_A_NS, CLK_NS);
  localparam int WAIT_CYC = toCyc(MAX_WAIT_NS, CLK_NS);
  localparam int CNT_W    = $clog2(TA_CYC + WAIT_CYC + toCyc(cycleNs(0), CLK_NS) + 2);
  localparam int WAIT_W   = $clog2(WAIT_CYC + 2);
  localparam logic [CNT_W-1:0]  TA_LIM   = CNT_W'(TA_CYC);
  localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(WAIT_CYC);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic [CNT_W-1:0] setupTab [NUM_MODES];
  logic [CNT_W-1:0] pulseTab [NUM_MODES];
  logic [CNT_W-1:0] recTab   [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_modeTab
    assign setupTab[m] = CNT_W'(toCyc(setupNs(m), CLK_NS));
    assign pulseTab[m] = CNT_W'(toCyc(pulseNs(m), CLK_NS));
    assign recTab[m]   = CNT_W'(recCyc(m, CLK_NS));
  end

  pioState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [2:0]       modeQ;
  logic             doneQ;
  logic             errQ;

  logic sampled, holdOk, stall, tmo, exitAct;

  always_comb begin
    sampled = (cnt >= TA_LIM - ONE);
    holdOk  = (cnt >= pulseTab[modeQ] - ONE);
    stall   = sampled && !ioRdy;
    tmo     = stall && (waitCnt == WAIT_LIM);
    exitAct = (holdOk && ioRdy) || tmo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      waitCnt <= '0;
      modeQ   <= '0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state   <= ST_SETUP;
            cnt     <= '0;
            waitCnt <= '0;
            errQ    <= 1'b0;
            modeQ   <= (modeSel > 3'd4) ? 3'd4 : modeSel;
          end
        end
        ST_SETUP: begin
          if (cnt == setupTab[modeQ] - ONE) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_ACTIVE: begin
          if (exitAct) begin
            state <= ST_RECOVER;
            cnt   <= '0;
            errQ  <= tmo;
          end else begin
            cnt <= cnt + ONE;
            if (stall) waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        default: begin
          if (cnt == recTab[modeQ] - ONE) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.load     = (state == ST_IDLE) && reqValid;
    ctl.driveBus = (state != ST_IDLE);
    ctl.strobeOn = (state == ST_ACTIVE);
    ctl.capture  = (state == ST_ACTIVE) && exitAct;
  end

  assign busy       = (state != ST_IDLE);
  assign done       = doneQ;
  assign timeoutErr = errQ;

  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rstN) doneQ |=> !doneQ);                  // R2
  AST_BUSY_IGNORE:   assert property (@(posedge clk) disable iff (!rstN) (busy && reqValid) |=> $stable(modeQ)); // R10
  AST_WAIT_BOUND:    assert property (@(posedge clk) disable iff (!rstN) waitCnt <= WAIT_LIM);               // R9
  AST_ERR_AT_EXIT:   assert property (@(posedge clk) disable iff (!rstN) $rose(errQ) |-> state == ST_RECOVER); // R9

endmodule

// File: rtl/pio_host_dpath.sv
`timescale 1ns/1ps
module pio_host_dpath
  import pio_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioCtl_t           ctl,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [CS_W-1:0]   busCsN,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [CS_W-1:0]   csQ;
  logic              wrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      csQ    <= '0;
      wrQ    <= 1'b0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        csQ    <= reqCs;
        wrQ    <= reqWrite;
        wdataQ <= reqWdata;
      end
      if (ctl.capture && !wrQ) rdQ <= busDataIn;
    end
  end

  assign busAddr    = addrQ;
  assign busCsN     = ~(csQ & {CS_W{ctl.driveBus}});
  assign busRdN     = ~(ctl.strobeOn & ~wrQ);
  assign busWrN     = ~(ctl.strobeOn & wrQ);
  assign busDataOut = wdataQ;
  assign busDataOe  = ctl.driveBus & wrQ;
  assign rdData     = rdQ;

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busRdN) || $fell(busWrN)) |-> $past(ctl.driveBus));                              // R3
  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rstN)
    $past(!busRdN || !busWrN) |-> ($stable(busAddr) && $stable(busCsN)));                  // R12
  AST_WR_DRIVE:    assert property (@(posedge clk) disable iff (!rstN) !busWrN |-> busDataOe);  // R7
  AST_RD_FLOAT:    assert property (@(posedge clk) disable iff (!rstN) !busRdN |-> !busDataOe); // R6

endmodule

// File: rtl/pio_host_seq.sv
`timescale 1ns/1ps
module pio_host_seq
  import pio_host_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int MAX_WAIT_NS = 1250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqCs,
  input  logic [2:0]  reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [2:0]  modeSel,
  output logic        busy,
  output logic        done,
  output logic        timeoutErr,
  output logic [15:0] rdData,
  output logic [2:0]  busAddr,
  output logic [1:0]  busCsN,
  output logic        busRdN,
  output logic        busWrN,
  output logic [15:0] busDataOut,
  output logic        busDataOe,
  input  logic [15:0] busDataIn,
  input  logic        ioRdy
);

  pioCtl_t ctl;

  pio_host_ctrl #(.CLK_NS(CLK_NS), .MAX_WAIT_NS(MAX_WAIT_NS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeSel(modeSel), .ioRdy(ioRdy),
    .ctl(ctl), .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  pio_host_dpath #(.DATA_W(16), .ADDR_W(3), .CS_W(2)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqCs(reqCs),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDataIn(busDataIn), .rdData(rdData),
    .busAddr(busAddr), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

endmodule

// File: tb/test_pio_host_seq.sv
`timescale 1ns/1ps
module test_pio_host_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqCs = 2'b00;
  logic [2:0]  reqAddr = 3'd0;
  logic [15:0] reqWdata = 16'h0;
  logic [2:0]  modeSel = 3'd0;
  logic [15:0] busDataIn = 16'h0;
  logic        ioRdy = 1'b1;
  logic        busy, done, timeoutErr, busRdN, busWrN, busDataOe;
  logic [15:0] rdData, busDataOut;
  logic [2:0]  busAddr;
  logic [1:0]  busCsN;

  int nChecks = 0;
  int nFails  = 0;

  // measured values of the last transfer
  int mSetup, mLow, mRec;
  logic [15:0] mRd;
  logic mErr, mDone, mBusBad, mBusyBad;

  always #2.5 clk = ~clk;

  pio_host_seq i_pio_host_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqCs(reqCs),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .modeSel(modeSel), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .rdData(rdData), .busAddr(busAddr), .busCsN(busCsN),
    .busRdN(busRdN), .busWrN(busWrN), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .ioRdy(ioRdy)
  );

  function automatic int cyc(int ns);
    return ((ns + 4) / 5 < 1) ? 1 : (ns + 4) / 5;
  endfunction

  function automatic int expSetup(int m);
    int t [5] = '{70, 50, 30, 30, 25};
    return cyc(t[m]);
  endfunction
  function automatic int expLow(int m);
    int t [5] = '{165, 125, 100, 80, 70};
    return cyc(t[m]);
  endfunction
  function automatic int expRec(int m);
    int t0 [5] = '{600, 383, 240, 180, 120};
    int ti [5] = '{0, 0, 0, 70, 25};
    int t4 [5] = '{30, 20, 15, 10, 10};
    int t9 [5] = '{20, 15, 10, 10, 10};
    int r;
    r = cyc(ti[m]);
    if (cyc(t4[m]) > r) r = cyc(t4[m]);
    if (cyc(t9[m]) > r) r = cyc(t9[m]);
    if (cyc(t0[m]) - expSetup(m) - expLow(m) > r) r = cyc(t0[m]) - expSetup(m) - expLow(m);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runXfer(input logic wr, input logic [1:0] cs, input logic [2:0] addr,
                         input logic [15:0] wd, input logic [2:0] mode, input int relAt,
                         input logic [15:0] rdv, input logic poke);
    int guard;
    logic stb, other;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqCs = cs; reqAddr = addr; reqWdata = wd; modeSel = mode;
    ioRdy = (relAt == 0);
    @(negedge clk);
    reqValid = 1'b0;
    mSetup = 0; mLow = 0; mRec = 0; mDone = 1'b0; mBusBad = 1'b0; mBusyBad = 1'b0;
    mErr = 1'b0; mRd = 16'h0; guard = 0;
    while (!mDone && guard < 3000) begin
      if (done) begin
        mDone = 1'b1; mRd = rdData; mErr = timeoutErr;
        if (busy) mBusyBad = 1'b1;
      end else begin
        if (!busy) mBusyBad = 1'b1;
        if (busDataOe != wr || (wr && busDataOut != wd)) mBusBad = 1'b1;
        if (busAddr != addr || busCsN != ~cs) mBusBad = 1'b1;
        stb   = wr ? busWrN : busRdN;
        other = wr ? busRdN : busWrN;
        if (!other) mBusBad = 1'b1;
        if (!stb) begin
          mLow++;
          busDataIn = rdv;
          if (relAt > 0 && mLow == relAt) ioRdy = 1'b1;
        end else begin
          if (mLow > 0) mRec++; else mSetup++;
          busDataIn = 16'hDEAD;
        end
        if (poke && guard == 3) begin
          reqValid = 1'b1; reqAddr = ~addr; reqWrite = ~wr; reqCs = ~cs; modeSel = 3'd0;
        end
        if (poke && guard == 5) reqValid = 1'b0;
        guard++;
        @(negedge clk);
      end
    end
    ioRdy = 1'b1;
    busDataIn = 16'h0;
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", timeoutErr, 0);
    chk("R1 cs", busCsN, 3);
    chk("R1 strobes", {busRdN, busWrN}, 3);
    chk("R1 oe", busDataOe, 0);
  endtask

  task automatic testRead(input int m, input logic [15:0] v);
    runXfer(1'b0, 2'b01, 3'd7, 16'h0, 3'(m), 0, v, 1'b0);
    chk("R2 done seen", mDone, 1);
    chk("R2 busy window", mBusyBad, 0);
    chk("R3 setup", mSetup, expSetup(m));
    chk("R4 strobe width", mLow, expLow(m));
    chk("R5 recovery", mRec, expRec(m));
    chk("R6 read data", mRd, v);
    chk("R12 bus stable / R6 no drive", mBusBad, 0);
    chk("R9 no error", mErr, 0);
  endtask

  task automatic testWrite(input int m, input logic [15:0] v);
    runXfer(1'b1, 2'b10, 3'd2, v, 3'(m), 0, 16'h0, 1'b0);
    chk("R2 done seen", mDone, 1);
    chk("R3 setup", mSetup, expSetup(m));
    chk("R4 strobe width", mLow, expLow(m));
    chk("R5 recovery", mRec, expRec(m));
    chk("R7 write drive", mBusBad, 0);
    chk("R5 total cycle", mSetup + mLow + mRec, expSetup(m) + expLow(m) + expRec(m));
  endtask

  task automatic testStretch();
    runXfer(1'b0, 2'b01, 3'd0, 16'h0, 3'd4, 40, 16'hA5C3, 1'b0);
    chk("R8 stretched strobe", mLow, 40);
    chk("R8 read data", mRd, 16'hA5C3);
    chk("R8 no error", mErr, 0);
    chk("R8 recovery", mRec, expRec(4));
  endtask

  task automatic testTimeout();
    runXfer(1'b1, 2'b01, 3'd1, 16'h1234, 3'd4, 100000, 16'h0, 1'b0);
    chk("R9 wait limit", mLow, cyc(35) + cyc(1250));
    chk("R9 error flag", mErr, 1);
    chk("R9 done seen", mDone, 1);
    @(negedge clk);
    chk("R9 flag held", timeoutErr, 1);
    runXfer(1'b0, 2'b01, 3'd1, 16'h0, 3'd4, 0, 16'h0F0F, 1'b0);
    chk("R9 flag cleared", mErr, 0);
  endtask

  task automatic testBusyIgnore();
    runXfer(1'b0, 2'b01, 3'd5, 16'h0, 3'd2, 0, 16'h7E81, 1'b1);
    chk("R10 bus kept", mBusBad, 0);
    chk("R10 mode kept", mSetup + mLow + mRec, expSetup(2) + expLow(2) + expRec(2));
    chk("R10 read data", mRd, 16'h7E81);
    @(negedge clk);
    chk("R10 no extra cycle busy", busy, 0);
    chk("R10 no extra cycle cs", busCsN, 3);
  endtask

  task automatic testClamp();
    runXfer(1'b0, 2'b11, 3'd3, 16'h0, 3'd7, 0, 16'h3C3C, 1'b0);
    chk("R11 setup", mSetup, expSetup(4));
    chk("R11 strobe", mLow, expLow(4));
    chk("R11 recovery", mRec, expRec(4));
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead(4, 16'hBEEF);
    testRead(0, 16'h1357);
    testWrite(1, 16'hC001);
    testWrite(4, 16'h5AA5);
    testStretch();
    testTimeout();
    testBusyIgnore();
    testClamp();
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule